// File: doc/BRIEF.md
# Burst Refresh Scheduler

This block decides when a memory controller must stop normal traffic to refresh the attached DRAM. It does not send one refresh per refresh interval. Instead it lets refreshes accumulate. When BURST_N intervals have passed, it asks the command arbiter for the bus. Once the arbiter grants the bus, it closes every bank with a precharge-all command. It then sends BURST_N refresh commands back to back. Each command keeps to the row-precharge and refresh-cycle spacing of the device.

A single interval counter runs on the controller clock. While the controller keeps the memory in self refresh or power down, it drives `pause` high. The counter is then cleared and held, and it restarts from zero when `pause` falls. The counter keeps running while a request waits for grant and while a burst is in progress. Any whole period that ends in that time is remembered and is served by a later burst.

After the last refresh wait of a burst, the block releases the bus. When retraining is enabled, it then raises `retrain_req` and holds it until the I/O logic answers with `retrain_ack`. The arbiter handshake is a plain request/grant pair:
- `bus_req` stays high until the burst ends, whatever `bus_gnt` does.
- `bus_gnt` is looked at only while a request is waiting.
- The arbiter should give the bus to nothing else while `bus_req` is high.

Top module: `refresh_burst_sched`

## Requirements
- R1: While `rst_n` is low, `bus_req`, `cmd_valid`, `busy` and `retrain_req` are all low and `cmd_code` is 0 (no command).
- R2: After reset, with `pause` low, one burst period of P = INTERVAL_CLKS*BURST_N clock edges is counted. `bus_req` rises on edge P+1 and not before.
- R3: A clock edge that samples `pause` high clears the interval counter and holds it at zero. After `pause` falls, `bus_req` rises on edge P+1 counted from the release, as in R2.
- R4: `bus_gnt` acts only while a request waits (`bus_req` high, `busy` low). At other times it starts nothing. On the edge after a sampled grant, `busy` rises and a precharge-all is issued (`cmd_valid` high, `cmd_code` = 1) for one cycle.
- R5: The first refresh (`cmd_code` = 2) is issued TRP cycles after the precharge-all. The remaining BURST_N-1 refreshes follow at a spacing of TRFC cycles. `cmd_valid` is low in every other cycle. TRP and TRFC are at least 2.
- R6: `busy` stays high from the precharge-all cycle through the TRFC-1 cycles that follow the last refresh, and while retraining is pending.
- R7: Once raised, `bus_req` stays high through the request wait and the whole burst. It falls in the cycle after the last refresh wait ends.
- R8: With RETRAIN_EN=1, `retrain_req` rises when the bus is released and holds with `busy` until `retrain_ack` is sampled high. On the next edge both fall.
- R9: With RETRAIN_EN=0, `retrain_req` never rises, and `busy` falls in the cycle after the last refresh wait.
- R10: Periods that end while a request waits or a burst runs are counted (up to PEND_MAX). A counted period raises `bus_req` again one cycle after the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pause | input | 1 | High while the memory is in self refresh or power down; clears and holds the interval counter |
| bus_gnt | input | 1 | Grant from the command arbiter |
| retrain_ack | input | 1 | I/O retraining finished |
| bus_req | output | 1 | Request for the command bus, held through the burst |
| cmd_valid | output | 1 | A command is presented this cycle |
| cmd_code | output | 2 | 0 none, 1 precharge all, 2 auto refresh |
| busy | output | 1 | A burst or its retraining is in progress |
| retrain_req | output | 1 | Request for I/O retraining after a burst |

## Verification
A wrong interval count shows at `bus_req` on the first request after reset or after a pause, a full P+1 edges later, so each request edge is checked against its exact cycle. A gap timer or refresh counter that is off by one moves a `cmd_valid` pulse, or adds or drops one, within TRFC cycles of the fault. For that reason every cycle of a burst is compared. A lost pending period shows only after the burst that covered it, as a missing second request one cycle after the return to idle. A sequencer stuck in retraining shows as `busy` that does not fall on the edge after the acknowledge.

// File: rtl/rfsh_sched_pkg.sv
package rfsh_sched_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_PREA = 2'd1,
    CMD_REF  = 2'd2
  } rfsh_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_PRE,
    S_PGAP,
    S_REF,
    S_RGAP,
    S_TRAIN
  } rfsh_state_e;

endpackage

// File: rtl/rfsh_interval_tracker.sv
// Counts burst periods of INTERVAL_CLKS*BURST_N clocks and keeps how many are owed.
module rfsh_interval_tracker #(
  parameter int INTERVAL_CLKS = 1040,
  parameter int BURST_N       = 8,
  parameter int PEND_MAX      = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pause,
  input  logic take,
  output logic pend_any
);
  localparam int PERIOD = INTERVAL_CLKS * BURST_N;
  localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam int PEND_W = $clog2(PEND_MAX + 1);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(PERIOD - 1);
  localparam logic [PEND_W-1:0] PEND_TOP = PEND_W'(PEND_MAX);

  logic [CNT_W-1:0]  cnt_q;
  logic [PEND_W-1:0] pend_q;
  logic              wrap;

  assign wrap = !pause && (cnt_q == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (pause || wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      case ({wrap, take})
        2'b10:   if (pend_q != PEND_TOP) pend_q <= pend_q + 1'b1;
        2'b01:   pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q;
      endcase
    end
  end

  assign pend_any = (pend_q != '0);
endmodule

// File: rtl/rfsh_gap_timer.sv
// Down counter for command spacing; expired is high once it reaches zero.
module rfsh_gap_timer #(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  output logic             expired
);
  logic [GAP_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign expired = (left_q == '0);
endmodule

// File: rtl/rfsh_burst_fsm.sv
// Sequencer: request, precharge-all, BURST_N spaced refreshes, optional retrain.
module rfsh_burst_fsm
  import rfsh_sched_pkg::*;
#(
  parameter int BURST_N    = 8,
  parameter int TRP        = 3,
  parameter int TRFC       = 15,
  parameter bit RETRAIN_EN = 1'b1,
  parameter int GAP_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_any,
  input  logic             bus_gnt,
  input  logic             retrain_ack,
  input  logic             gap_done,
  output logic             take,
  output logic             gap_load,
  output logic [GAP_W-1:0] gap_val,
  output logic             bus_req,
  output logic             busy,
  output logic             cmd_valid,
  output rfsh_cmd_e        cmd_code,
  output logic             retrain_req
);
  localparam int REF_W = $clog2(BURST_N + 1);
  localparam logic [REF_W-1:0] REF_LAST  = REF_W'(BURST_N);
  localparam logic [GAP_W-1:0] TRP_LOAD  = GAP_W'(TRP - 2);
  localparam logic [GAP_W-1:0] TRFC_LOAD = GAP_W'(TRFC - 2);
  localparam rfsh_state_e      AFTER_BURST = RETRAIN_EN ? S_TRAIN : S_IDLE;

  rfsh_state_e      state_q, state_d;
  logic [REF_W-1:0] refs_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (pend_any) state_d = S_REQ;
      S_REQ:   if (bus_gnt) state_d = S_PRE;
      S_PRE:   state_d = S_PGAP;
      S_PGAP:  if (gap_done) state_d = S_REF;
      S_REF:   state_d = S_RGAP;
      S_RGAP:  if (gap_done) state_d = (refs_q == REF_LAST) ? AFTER_BURST : S_REF;
      S_TRAIN: if (retrain_ack) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      refs_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_PRE) begin
        refs_q <= '0;
      end else if (state_q == S_REF) begin
        refs_q <= refs_q + 1'b1;
      end
    end
  end

  assign take        = (state_q == S_REQ) && bus_gnt;
  assign gap_load    = (state_q == S_PRE) || (state_q == S_REF);
  assign gap_val     = (state_q == S_PRE) ? TRP_LOAD : TRFC_LOAD;
  assign bus_req     = state_q inside {S_REQ, S_PRE, S_PGAP, S_REF, S_RGAP};
  assign busy        = state_q inside {S_PRE, S_PGAP, S_REF, S_RGAP, S_TRAIN};
  assign cmd_valid   = (state_q == S_PRE) || (state_q == S_REF);
  assign cmd_code    = (state_q == S_PRE) ? CMD_PREA :
                       (state_q == S_REF) ? CMD_REF  : CMD_NONE;
  assign retrain_req = (state_q == S_TRAIN);
endmodule

// File: rtl/refresh_burst_sched.sv
module refresh_burst_sched #(
  parameter int INTERVAL_CLKS = 1040,
  parameter int BURST_N       = 8,
  parameter int TRP           = 3,
  parameter int TRFC          = 15,
  parameter bit RETRAIN_EN    = 1'b1,
  parameter int PEND_MAX      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pause,
  input  logic       bus_gnt,
  input  logic       retrain_ack,
  output logic       bus_req,
  output logic       cmd_valid,
  output logic [1:0] cmd_code,
  output logic       busy,
  output logic       retrain_req
);
  import rfsh_sched_pkg::*;

  localparam int GAP_MAX = (TRP > TRFC) ? TRP : TRFC;
  localparam int GAP_W   = $clog2(GAP_MAX);

  logic             pend_any, take, gap_load, gap_done;
  logic [GAP_W-1:0] gap_val;
  rfsh_cmd_e        cmd_e;

  rfsh_interval_tracker #(
    .INTERVAL_CLKS(INTERVAL_CLKS),
    .BURST_N      (BURST_N),
    .PEND_MAX     (PEND_MAX)
  ) u_track (
    .clk     (clk),
    .rst_n   (rst_n),
    .pause   (pause),
    .take    (take),
    .pend_any(pend_any)
  );

  rfsh_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .load_val(gap_val),
    .expired (gap_done)
  );

  rfsh_burst_fsm #(
    .BURST_N   (BURST_N),
    .TRP       (TRP),
    .TRFC      (TRFC),
    .RETRAIN_EN(RETRAIN_EN),
    .GAP_W     (GAP_W)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_any   (pend_any),
    .bus_gnt    (bus_gnt),
    .retrain_ack(retrain_ack),
    .gap_done   (gap_done),
    .take       (take),
    .gap_load   (gap_load),
    .gap_val    (gap_val),
    .bus_req    (bus_req),
    .busy       (busy),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_e),
    .retrain_req(retrain_req)
  );

  assign cmd_code = cmd_e;
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter bit RETRAIN_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_gnt,
  input logic       retrain_ack,
  input logic       bus_req,
  input logic       cmd_valid,
  input logic [1:0] cmd_code,
  input logic       busy,
  input logic       retrain_req
);
  AST_CMD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> busy && bus_req); // R6
  AST_CMD_SPACED: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid); // R5
  AST_CODE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |-> cmd_code != 2'd0); // R5
  AST_GRANT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !busy && bus_gnt) |=> (busy && cmd_valid && cmd_code == 2'd1)); // R4
  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !busy && !bus_gnt) |=> bus_req); // R7
  AST_TRAIN_OFF_BUS: assert property (@(posedge clk) disable iff (!rst_n) retrain_req |-> busy && !bus_req); // R8
  AST_TRAIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_req && !retrain_ack) |=> retrain_req); // R8
  AST_TRAIN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_req && retrain_ack) |=> !retrain_req && !busy); // R8

  if (!RETRAIN_EN) begin : g_no_train
    AST_NO_TRAIN: assert property (@(posedge clk) disable iff (!rst_n) !retrain_req); // R9
  end
endmodule

bind refresh_burst_sched rfsh_sched_chk #(.RETRAIN_EN(RETRAIN_EN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_gnt    (bus_gnt),
  .retrain_ack(retrain_ack),
  .bus_req    (bus_req),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .busy       (busy),
  .retrain_req(retrain_req)
);

// File: tb/sim_refresh_burst_sched.sv
module sim_refresh_burst_sched;
  localparam int IV   = 8;
  localparam int NB   = 3;
  localparam int RP   = 2;
  localparam int RFC  = 4;
  localparam int P    = IV * NB;
  localparam int JEND = RP + NB * RFC + 1;

  localparam int IV1  = 6;
  localparam int RP1  = 3;
  localparam int RFC1 = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pause = 1'b0, gnt = 1'b0, ack = 1'b0;
  logic bus_req, cmd_valid, busy, retrain_req;
  logic [1:0] cmd_code;
  logic bus_req1, cmd_valid1, busy1, retrain_req1;
  logic [1:0] cmd_code1;

  int checks = 0;
  int errors = 0;
  bit u1_done = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  refresh_burst_sched #(.INTERVAL_CLKS(IV), .BURST_N(NB), .TRP(RP), .TRFC(RFC),
                        .RETRAIN_EN(1'b1), .PEND_MAX(3)) u0 (
    .clk(clk), .rst_n(rst_n), .pause(pause), .bus_gnt(gnt), .retrain_ack(ack),
    .bus_req(bus_req), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .busy(busy), .retrain_req(retrain_req));

  refresh_burst_sched #(.INTERVAL_CLKS(IV1), .BURST_N(1), .TRP(RP1), .TRFC(RFC1),
                        .RETRAIN_EN(1'b0), .PEND_MAX(3)) u1 (
    .clk(clk), .rst_n(rst_n), .pause(1'b0), .bus_gnt(1'b1), .retrain_ack(1'b0),
    .bus_req(bus_req1), .cmd_valid(cmd_valid1), .cmd_code(cmd_code1),
    .busy(busy1), .retrain_req(retrain_req1));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Cycle j after the grant edge: expected command and flags of u0.
  task automatic burst_check();
    for (int j = 1; j <= JEND; j++) begin
      int rel;
      bit is_ref;
      step();
      gnt = 1'b0;
      rel = j - 1 - RP;
      is_ref = (rel >= 0) && (rel % RFC == 0) && (rel / RFC < NB);
      chk("R5", "cmd_valid", int'(cmd_valid), int'((j == 1) || is_ref));
      if (j == 1) chk("R4", "cmd_code prea", int'(cmd_code), 1);
      if (is_ref) chk("R5", "cmd_code ref", int'(cmd_code), 2);
      chk("R6", "busy", int'(busy), 1);
      chk("R7", "bus_req", int'(bus_req), int'(j < JEND));
      chk("R8", "retrain_req", int'(retrain_req), int'(j == JEND));
    end
  endtask

  // Second instance: BURST_N=1, no retraining, grant tied high.
  initial begin
    @(posedge rst_n);
    for (int k = 1; k <= 17; k++) begin
      bit ex_req, ex_busy;
      step();
      ex_busy = (k >= 8) && (k <= 15);
      ex_req  = (k == 7) || ex_busy || (k == 17);
      chk("R9", "u1 bus_req", int'(bus_req1), int'(ex_req));
      chk("R9", "u1 busy", int'(busy1), int'(ex_busy));
      chk("R9", "u1 retrain_req", int'(retrain_req1), 0);
      chk("R5", "u1 cmd_valid", int'(cmd_valid1), int'((k == 8) || (k == 11)));
      if (k == 8)  chk("R4", "u1 cmd_code", int'(cmd_code1), 1);
      if (k == 11) chk("R5", "u1 cmd_code", int'(cmd_code1), 2);
    end
    u1_done = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "bus_req", int'(bus_req), 0);
    chk("R1", "cmd_valid", int'(cmd_valid), 0);
    chk("R1", "cmd_code", int'(cmd_code), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "retrain_req", int'(retrain_req), 0);
    chk("R1", "u1 bus_req", int'(bus_req1), 0);
    rst_n = 1'b1;

    // Partial count, then a long pause with a stray grant.
    for (int k = 1; k <= 10; k++) begin
      step();
      chk("R2", "bus_req early", int'(bus_req), 0);
    end
    pause = 1'b1;
    gnt = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      step();
      chk("R3", "bus_req paused", int'(bus_req), 0);
      chk("R4", "cmd_valid stray grant", int'(cmd_valid), 0);
      chk("R4", "busy stray grant", int'(busy), 0);
    end
    pause = 1'b0;
    gnt = 1'b0;
    for (int k = 1; k <= P + 1; k++) begin
      step();
      chk("R3", "bus_req after pause", int'(bus_req), int'(k == P + 1));
    end

    // Hold off the grant across a second period.
    for (int k = P + 2; k <= 2 * P + 1; k++) begin
      step();
      chk("R7", "bus_req waiting", int'(bus_req), 1);
      chk("R4", "busy waiting", int'(busy), 0);
    end

    gnt = 1'b1;
    burst_check();
    step();
    chk("R8", "retrain_req held", int'(retrain_req), 1);
    chk("R8", "busy held", int'(busy), 1);
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R8", "busy after ack", int'(busy), 0);
    chk("R8", "retrain_req after ack", int'(retrain_req), 0);
    chk("R8", "bus_req after ack", int'(bus_req), 0);
    step();
    chk("R10", "pending period re-request", int'(bus_req), 1);

    gnt = 1'b1;
    burst_check();
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R8", "busy after second ack", int'(busy), 0);

    wait (u1_done);
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule